// File: doc/BRIEF.md
# High-Page Load/Store Sequencer

This block executes the four short-form instructions of an 8-bit CPU that reach the top 256-byte page of the address space. The fetch stage hands it an opcode together with the byte that follows it. The register file supplies the current A and C values. The block then builds a 16-bit address whose upper byte is fixed at 0xFF. The lower byte is either the operand byte or the value of C. The block performs one byte transfer over a plain memory port and reports completion after the correct number of clock cycles.

A machine cycle is four clocks long. The two immediate-offset forms take three machine cycles: opcode, operand and data. The two C-offset forms take two machine cycles: opcode and data. The memory transfer always occupies the final machine cycle. A load writes A on the closing edge of the instruction through a write-enable output. Opcodes outside the four recognised ones are refused, and a flag reports each refusal.

Top module: `hp_seq`

## Requirements
- R1: While the memory request is high, the address equals 0xFF in bits 15:8 joined to an offset in bits 7:0. The offset is the operand byte for opcodes 0xE0 and 0xF0, and the C value for 0xE2 and 0xF2. Both are sampled when the instruction is accepted. While no request is active, the address reads zero.
- R2: Opcodes 0xE0 and 0xE2 are stores. During the data cycle they hold the write strobe high and drive the write data with the A value sampled at acceptance. The write data reads zero whenever the strobe is low.
- R3: Opcodes 0xF0 and 0xF2 are loads. In the final clock they raise the A write enable and drive A write data equal to the memory read data. A store never raises the A write enable.
- R4: An accepted 0xE0 or 0xF0 keeps busy high for exactly 12 clocks following the accepting edge.
- R5: An accepted 0xE2 or 0xF2 keeps busy high for exactly 8 clocks following the accepting edge.
- R6: The memory request is high for exactly the last 4 busy clocks of each instruction and at no other time.
- R7: Done is high for exactly one clock per instruction, which is the last busy clock.
- R8: A start with any other opcode while idle starts nothing. Busy, request and A write enable stay low, and the illegal flag is high for the single following clock.
- R9: A start while busy is ignored. It neither restarts the instruction nor raises the illegal flag.
- R10: During reset and in the clock after it, busy, done, request, write strobe, A write enable and the illegal flag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Instruction offered this clock |
| opcode | input | 8 | Opcode byte |
| operand | input | 8 | Byte following the opcode |
| reg_a | input | 8 | Current A register |
| reg_c | input | 8 | Current C register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last clock of the instruction |
| illegal | output | 1 | Previous clock refused an unknown opcode |
| mem_req | output | 1 | Memory transfer active |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the final clock |
| a_we | output | 1 | Write A this edge |
| a_wdata | output | 8 | Value to write to A |

## Verification
The checker watches invariants on every cycle. It confirms that requests happen only inside busy periods and carry the 0xFF page, and that the address holds steady through the data cycle. It also confirms that done ends a busy period, that A writes appear only at done and never alongside a memory write, and that a refusal never coincides with activity. The exact 8- and 12-clock lengths, the placement of the data cycle, the choice between operand and C, and the way a busy start is ignored are visible only through the bench scenarios. The same holds for the round trip of a stored byte read back by a later load.

// File: rtl/hp_pkg.sv
// Shared opcode table and decode types for the high-page sequencer.
// Assumes byte-wide opcodes and four recognised encodings.
package hp_pkg;
    localparam logic [7:0] OP_ST_IMM = 8'hE0;
    localparam logic [7:0] OP_LD_IMM = 8'hF0;
    localparam logic [7:0] OP_ST_C   = 8'hE2;
    localparam logic [7:0] OP_LD_C   = 8'hF2;
    localparam int NUM_OPS = 4;

    typedef struct packed {
        logic legal;
        logic is_store;
        logic uses_imm;
    } op_info_t;

    typedef struct packed {
        logic [7:0] code;
        logic       is_store;
        logic       uses_imm;
    } op_entry_t;

    // Return table row idx of the recognised opcodes.
    function automatic op_entry_t op_table(input int idx);
        op_entry_t e;
        case (idx)
            0:       e = '{code: OP_ST_IMM, is_store: 1'b1, uses_imm: 1'b1};
            1:       e = '{code: OP_LD_IMM, is_store: 1'b0, uses_imm: 1'b1};
            2:       e = '{code: OP_ST_C,   is_store: 1'b1, uses_imm: 1'b0};
            default: e = '{code: OP_LD_C,   is_store: 1'b0, uses_imm: 1'b0};
        endcase
        return e;
    endfunction
endpackage

// File: rtl/hp_decode.sv
// Combinational opcode decoder: matches the opcode against each table row
// and reports whether it is legal, a store, and whether it uses the operand.
// Assumes table rows hold distinct codes.
module hp_decode
    import hp_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);
    logic [NUM_OPS-1:0] hit;
    logic [NUM_OPS-1:0] st_bit;
    logic [NUM_OPS-1:0] imm_bit;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_row
        localparam op_entry_t ROW = op_table(i);
        assign hit[i]     = (opcode == ROW.code);
        assign st_bit[i]  = ROW.is_store;
        assign imm_bit[i] = ROW.uses_imm;
    end

    // Fold the per-row matches into one descriptor.
    always_comb begin
        info.legal    = |hit;
        info.is_store = |(hit & st_bit);
        info.uses_imm = |(hit & imm_bit);
    end
endmodule

// File: rtl/hp_phase_ctr.sv
// Clock counter for one instruction: launched with a machine-cycle count,
// it holds busy for count*CLKS_PER_MC clocks, flags the last clock and the
// final machine cycle (the data cycle). Assumes mc_count >= 1 at launch.
module hp_phase_ctr #(
    parameter int CLKS_PER_MC = 4,
    parameter int MAX_MC      = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic [$clog2(MAX_MC+1)-1:0] mc_count,
    output logic                      busy,
    output logic                      last,
    output logic                      data_phase
);
    localparam int MAX_CLKS = CLKS_PER_MC * MAX_MC;
    localparam int CW       = $clog2(MAX_CLKS + 1);

    logic [CW-1:0] k_q;
    logic [CW-1:0] lim_q;
    logic [CW-1:0] lim_d;
    logic          busy_q;

    // Final clock index for the launched instruction.
    always_comb lim_d = CW'(int'(mc_count) * CLKS_PER_MC - 1);

    // Advance the clock index while an instruction is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            k_q    <= '0;
            lim_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            k_q    <= '0;
            lim_q  <= lim_d;
        end else if (busy_q) begin
            if (k_q == lim_q) busy_q <= 1'b0;
            else              k_q    <= k_q + CW'(1);
        end
    end

    assign busy       = busy_q;
    assign last       = busy_q && (k_q == lim_q);
    assign data_phase = busy_q &&
        (({1'b0, k_q} + (CW+1)'(CLKS_PER_MC)) > {1'b0, lim_q});
endmodule

// File: rtl/hp_addr_gen.sv
// Captures offset and store data at launch and forms the page address
// by joining the fixed upper byte to the offset (no arithmetic).
module hp_addr_gen #(
    parameter int          DW   = 8,
    parameter logic [DW-1:0] PAGE = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic            use_imm,
    input  logic [DW-1:0]   operand,
    input  logic [DW-1:0]   reg_c,
    input  logic [DW-1:0]   reg_a,
    output logic [2*DW-1:0] addr,
    output logic [DW-1:0]   a_held
);
    logic [DW-1:0] off_q;
    logic [DW-1:0] a_q;

    // Latch offset source and A value when an instruction starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            a_q   <= '0;
        end else if (launch) begin
            off_q <= use_imm ? operand : reg_c;
            a_q   <= reg_a;
        end
    end

    assign addr   = {PAGE, off_q};
    assign a_held = a_q;
endmodule

// File: rtl/hp_seq.sv
// Top of the high-page load/store sequencer. Accepts one legal opcode while
// idle, runs 2 or 3 machine cycles, moves one byte in the last one, and
// flags unknown opcodes. Assumes memory read data is valid in the last clock.
module hp_seq #(
    parameter int            DW          = 8,
    parameter logic [DW-1:0] PAGE        = '1,
    parameter int            CLKS_PER_MC = 4,
    parameter int            MC_IMM      = 3,
    parameter int            MC_REG      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [DW-1:0]   operand,
    input  logic [DW-1:0]   reg_a,
    input  logic [DW-1:0]   reg_c,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic            mem_req,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            a_we,
    output logic [DW-1:0]   a_wdata
);
    import hp_pkg::*;

    localparam int MAX_MC = (MC_IMM > MC_REG) ? MC_IMM : MC_REG;
    localparam int MCW    = $clog2(MAX_MC + 1);

    op_info_t        info;
    logic            launch;
    logic            store_q;
    logic            illegal_q;
    logic [MCW-1:0]  mc_count;
    logic            data_phase;
    logic [2*DW-1:0] addr_full;
    logic [DW-1:0]   a_held;

    hp_decode u_dec (
        .opcode (opcode),
        .info   (info)
    );

    assign launch   = start && !busy && info.legal;
    assign mc_count = info.uses_imm ? MCW'(MC_IMM) : MCW'(MC_REG);

    hp_phase_ctr #(.CLKS_PER_MC(CLKS_PER_MC), .MAX_MC(MAX_MC)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .mc_count   (mc_count),
        .busy       (busy),
        .last       (done),
        .data_phase (data_phase)
    );

    hp_addr_gen #(.DW(DW), .PAGE(PAGE)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .use_imm (info.uses_imm),
        .operand (operand),
        .reg_c   (reg_c),
        .reg_a   (reg_a),
        .addr    (addr_full),
        .a_held  (a_held)
    );

    // Remember direction and report refused opcodes one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            if (launch) store_q <= info.is_store;
            illegal_q <= start && !busy && !info.legal;
        end
    end

    assign illegal   = illegal_q;
    assign mem_req   = data_phase;
    assign mem_we    = data_phase && store_q;
    assign mem_addr  = data_phase ? addr_full : '0;
    assign mem_wdata = mem_we ? a_held : '0;
    assign a_we      = done && !store_q;
    assign a_wdata   = mem_rdata;
endmodule

// File: rtl/hp_seq_chk.sv
// Cycle invariants of hp_seq, bound to every instance.
module hp_seq_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            mem_req,
    input logic            mem_we,
    input logic [2*DW-1:0] mem_addr,
    input logic            a_we
);
    // R6
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R1
    req_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2*DW-1:DW] == '1));
    // R1
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req) && $past(rst_n)) |-> $stable(mem_addr));
    // R2
    we_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
    // R3
    awe_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_we |-> (done && !mem_we));
    // R7
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R7
    done_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && mem_req));
    // R9
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_req));
endmodule

bind hp_seq hp_seq_chk #(.DW(DW)) u_hp_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .a_we     (a_we)
);

// File: tb/tb_hp_seq.sv
// Reference-model bench for hp_seq: a behavioural model predicts every
// output on every clock; a byte array stands in for the high page.
module tb_hp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, operand = 8'h00, reg_a = 8'h00, reg_c = 8'h00;
    logic        busy, done, illegal, mem_req, mem_we, a_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, a_wdata;

    always #5 clk = ~clk;

    hp_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .operand(operand), .reg_a(reg_a), .reg_c(reg_c),
        .busy(busy), .done(done), .illegal(illegal),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .a_we(a_we), .a_wdata(a_wdata)
    );

    // Page memory driven by the design's port.
    logic [7:0] hmem   [256];
    logic [7:0] refmem [256];
    initial for (int i = 0; i < 256; i++) begin
        hmem[i]   = 8'((i * 7 + 3) & 255);
        refmem[i] = 8'((i * 7 + 3) & 255);
    end
    assign mem_rdata = hmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && mem_we && done) hmem[mem_addr[7:0]] <= mem_wdata;

    // Reference model state.
    int         m_k = -1;
    int         m_t = 0;
    bit         m_st = 0;
    logic [7:0] m_off = 0, m_a = 0;
    bit         m_ill = 0;

    function automatic bit known(input logic [7:0] op);
        return op == 8'hE0 || op == 8'hF0 || op == 8'hE2 || op == 8'hF2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_k = -1; m_ill = 0;
        end else begin
            m_ill = start && (m_k < 0) && !known(opcode);
            if (m_k >= 0) begin
                if (m_k == m_t - 1) begin
                    if (m_st) refmem[m_off] = m_a;
                    m_k = -1;
                end else m_k++;
            end else if (start && known(opcode)) begin
                m_k   = 0;
                m_t   = (opcode[1] == 1'b0) ? 12 : 8;
                m_st  = (opcode[4] == 1'b0);
                m_off = (opcode[1] == 1'b0) ? operand : reg_c;
                m_a   = reg_a;
            end
        end
    end

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R10";

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) at %0t: actual %0h expected %0h", tag, cur_req, $time, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        bit e_busy, e_done, e_req, e_we, e_awe;
        e_busy = (m_k >= 0);
        e_done = e_busy && (m_k == m_t - 1);
        e_req  = e_busy && (m_k >= m_t - 4);
        e_we   = e_req && m_st;
        e_awe  = e_done && !m_st;
        vectors++;
        cmp("R4 R5 busy", int'(busy), int'(e_busy));
        cmp("R7 done", int'(done), int'(e_done));
        cmp("R6 mem_req", int'(mem_req), int'(e_req));
        cmp("R2 mem_we", int'(mem_we), int'(e_we));
        cmp("R1 mem_addr", int'(mem_addr), e_req ? int'({8'hFF, m_off}) : 0);
        cmp("R2 mem_wdata", int'(mem_wdata), e_we ? int'(m_a) : 0);
        cmp("R3 a_we", int'(a_we), int'(e_awe));
        if (e_awe) cmp("R3 a_wdata", int'(a_wdata), int'(refmem[m_off]));
        cmp("R8 illegal", int'(illegal), int'(m_ill));
    end

    task automatic issue(input logic [7:0] op, input logic [7:0] n,
                         input logic [7:0] a, input logic [7:0] c);
        @(posedge clk); #2;
        start = 1'b1; opcode = op; operand = n; reg_a = a; reg_c = c;
        @(posedge clk); #2;
        start = 1'b0; opcode = 8'h00;
    endtask

    task automatic settle();
        while (m_k >= 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    bit finished = 0;

    initial begin
        // R10: reset state
        cur_req = "R10";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        cur_req = "R1 R2 R4";
        issue(8'hE0, 8'h00, 8'hA5, 8'h11); settle();
        issue(8'hE0, 8'h7F, 8'h3C, 8'h22); settle();
        issue(8'hE0, 8'hFF, 8'h81, 8'h33); settle();

        cur_req = "R1 R3 R4";
        issue(8'hF0, 8'h7F, 8'h00, 8'h44); settle();
        issue(8'hF0, 8'h10, 8'h00, 8'h7F); settle();

        cur_req = "R1 R2 R5";
        issue(8'hE2, 8'h99, 8'h5A, 8'h80); settle();
        issue(8'hE2, 8'h00, 8'hC3, 8'hFE); settle();

        cur_req = "R1 R3 R5";
        issue(8'hF2, 8'h12, 8'h00, 8'h80); settle();
        issue(8'hF2, 8'h80, 8'h00, 8'h00); settle();

        cur_req = "R8";
        issue(8'h00, 8'h00, 8'h00, 8'h00); settle();
        issue(8'hE1, 8'h05, 8'h01, 8'h02); settle();
        issue(8'hF3, 8'h05, 8'h01, 8'h02); settle();

        // R9: second start during an active instruction is dropped
        cur_req = "R9";
        issue(8'hE0, 8'h40, 8'h66, 8'h00);
        repeat (2) @(posedge clk);
        issue(8'hF2, 8'h00, 8'h00, 8'h41);
        issue(8'h37, 8'h00, 8'h00, 8'h00);
        settle();
        issue(8'hF0, 8'h40, 8'h00, 8'h00); settle();

        cur_req = "R6 R7";
        for (int i = 0; i < 6; i++) begin
            issue((i % 2) ? 8'hF2 : 8'hE2, 8'h00, 8'(8'h10 + i), 8'(8'hF0 + i / 2));
            settle();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (%s): actual hung expected finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule